// File: doc/BRIEF.md
# Row-Structured Reconfigurable Functional-Unit Array

This block is the execution datapath for one custom instruction. Sixteen 32-bit functional units sit in five rows whose widths shrink from top to bottom: 6, 4, 3, 2 and 1 units. A single wide configuration word describes the instruction. For every unit, the word gives an opcode, two operand selects and an immediate. For every output port, it gives the unit whose result drives that port. A depth field sets the number of cycles the result takes.

When a start strobe is accepted, the block captures the eight operands and the configuration word. The captured values pass through the array, and after the configured latency the selected unit results are registered onto the outputs. A one-cycle done pulse marks this, together with per-output valid bits. Operands can enter the array at every row, not only the top one. A few fixed links let row 1 and row 2 results skip over intermediate rows. Each unit executes only the operations of its own class, plus a plain pass-through.

Top module: `afu_array`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done_o` is 0, every `res_vld_o` bit is 0 and every `res_o` lane is 0.
- R2: `cfg_i` holds these fields, listed from the least significant bit up:
  - depth in bits [2:0];
  - output select k in bits [3+5k+4 : 3+5k], made of an enable bit (its MSB) and a 4-bit unit number (its low bits);
  - unit g in bits [43+44g+43 : 43+44g], made of opcode [43:40], operand-A select [39:36], operand-B select [35:32] and immediate [31:0].
- R3: Units are numbered 0..15 row by row, with row widths 6, 4, 3, 2 and 1. Position p in a row (counted from 0) sets the class: p mod 3 = 0 is arithmetic, 1 is logical, 2 is shift.
- R4: Operand select 0 takes the unit's immediate. Selects 1.. take, in order:
  - the inputs offered to the row: row 1 gets inputs 0..6, row 2 gets 7 and 0, row 3 gets 1 and 2, row 4 gets 3 and 4, row 5 gets 5;
  - then the previous row's units, in ascending order;
  - then the row's skip links.
  A select past the last source gives 0.
- R5: The skip links, in select order, are:
  - row 3: unit 5;
  - row 4: unit 4, then unit 9;
  - row 5: unit 3.
- R6: Logical units execute XOR (1), NOR (2), AND (3) and OR (4) bitwise.
- R7: Arithmetic units execute ADD (5) and SUB (6) modulo 2^32. They also execute SLT (7), which gives 1 when A < B as signed numbers and 0 otherwise.
- R8: Shift units execute SLL (8) and SRL (9) of A by B[4:0], filling with zeros.
- R9: MOVE (0) forwards operand A on any unit. An opcode outside the unit's class, or any of codes 10..15, gives 0.
- R10: When output k's enable bit is set, `res_o[k]` is the result of the selected unit and `res_vld_o[k]` pulses with done. When it is clear, the lane is 0 and its valid bit stays 0.
- R11: `done_o` is a one-cycle pulse, L clock edges after the edge that accepts start. L is 1 for depth 0, 1 or 2, L is 2 for depth 3 or 4, and L is 3 for depth 5, 6 or 7.
- R12: Start is ignored while an instruction is in flight, including at the edge that delivers its result. Operands and configuration are sampled only at the accepting edge.
- R13: `res_o` holds its value in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, sampled when idle |
| opnd_i | input | 8x32 | Operand values, lane k = input k |
| cfg_i | input | 747 | Custom-instruction configuration word |
| res_o | output | 8x32 | Registered output lanes |
| res_vld_o | output | 8 | Per-lane valid, pulses with done |
| done_o | output | 1 | Completion pulse |

## Verification
The bench targets the edges of the source numbering:
- Inputs that enter at a lower row. A wrong offering table would read the wrong input lane.
- The skip links into rows 3, 4 and 5, and a select just past the last source. A wrong design would return a neighbour's result instead of 0.
- Class restriction and the undefined opcodes. A permissive unit would compute XOR on an adder or pass data through.
- SLT with mixed signs, and shifts by amounts of 32 or more. A wrong design would compare unsigned or fail to mask the amount.
- Every depth from 0 to 7, and start pulses that arrive mid-flight and at the result edge. Either a wrong latency table or a restart that corrupts captured operands would show up as a shifted or altered done pulse.

// File: rtl/afu_pkg.sv
package afu_pkg;

    localparam int DW     = 32;
    localparam int NIN    = 8;
    localparam int NOUT   = 8;
    localparam int NROW   = 5;
    localparam int NFU    = 16;
    localparam int OPW    = 4;
    localparam int SELW   = 4;
    localparam int DEPW   = 3;
    localparam int NCAND  = 1 << SELW;
    localparam int UIDW   = $clog2(NFU);
    localparam int SHW    = $clog2(DW);

    typedef enum logic [OPW-1:0] {
        OP_MOVE = 4'd0,
        OP_XOR  = 4'd1,
        OP_NOR  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_SLT  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CL_ARITH = 2'd0,
        CL_LOGIC = 2'd1,
        CL_SHIFT = 2'd2
    } cls_e;

    typedef struct packed {
        op_e             op;
        logic [SELW-1:0] sel_a;
        logic [SELW-1:0] sel_b;
        logic [DW-1:0]   imm;
    } fu_cfg_t;

    typedef struct packed {
        logic            en;
        logic [UIDW-1:0] src;
    } osel_t;

    typedef struct packed {
        fu_cfg_t [NFU-1:0]  fu;
        osel_t   [NOUT-1:0] osel;
        logic    [DEPW-1:0] depth;
    } ci_cfg_t;

    localparam int CFG_W = $bits(ci_cfg_t);

    function automatic int row_width(int r);
        case (r)
            0:       return 6;
            1:       return 4;
            2:       return 3;
            3:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int row_base(int r);
        int s;
        s = 0;
        for (int i = 0; i < r; i++) s += row_width(i);
        return s;
    endfunction

    // number of external operands offered to a row
    function automatic int row_nin(int r);
        if (r == 0) return 7;
        if (r == NROW-1) return 1;
        return 2;
    endfunction

    // which operand lane fills offered slot j of row r
    function automatic int row_in_idx(int r, int j);
        if (r == 0) return j;
        return (7 + 2*(r-1) + j) % NIN;
    endfunction

    function automatic int row_nskip(int r);
        case (r)
            2:       return 1;
            3:       return 2;
            4:       return 1;
            default: return 0;
        endcase
    endfunction

    // global unit index feeding skip link k of row r
    function automatic int skip_src(int r, int k);
        if (r == 2) return row_base(0) + 5;
        if (r == 3) return (k == 0) ? row_base(0) + 4 : row_base(1) + 3;
        return row_base(0) + 3;
    endfunction

    function automatic cls_e unit_cls(int pos);
        case (pos % 3)
            0:       return CL_ARITH;
            1:       return CL_LOGIC;
            default: return CL_SHIFT;
        endcase
    endfunction

    function automatic logic [1:0] lat_of(logic [DEPW-1:0] d);
        if (d <= 3'd2) return 2'd1;
        if (d <= 3'd4) return 2'd2;
        return 2'd3;
    endfunction

endpackage

// File: rtl/afu_unit.sv
module afu_unit
    import afu_pkg::*;
#(
    parameter cls_e CLS = CL_ARITH
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    localparam bit IS_LOG = (CLS == CL_LOGIC);
    localparam bit IS_ARI = (CLS == CL_ARITH);
    localparam bit IS_SHF = (CLS == CL_SHIFT);

    logic [SHW-1:0] amt;
    assign amt = b[SHW-1:0];

    always_comb begin
        y = '0;
        case (op)
            OP_MOVE: y = a;
            OP_XOR:  if (IS_LOG) y = a ^ b;
            OP_NOR:  if (IS_LOG) y = ~(a | b);
            OP_AND:  if (IS_LOG) y = a & b;
            OP_OR:   if (IS_LOG) y = a | b;
            OP_ADD:  if (IS_ARI) y = a + b;
            OP_SUB:  if (IS_ARI) y = a - b;
            OP_SLT:  if (IS_ARI) y[0] = ($signed(a) < $signed(b));
            OP_SLL:  if (IS_SHF) y = a << amt;
            OP_SRL:  if (IS_SHF) y = a >> amt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/afu_row.sv
module afu_row
    import afu_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic    [NIN-1:0][DW-1:0]           ext,
    input  logic    [NFU-1:0][DW-1:0]           fu_res,
    input  fu_cfg_t [NFU-1:0]                   fcfg,
    output logic    [row_width(ROW)-1:0][DW-1:0] row_y
);
    localparam int W    = row_width(ROW);
    localparam int BASE = row_base(ROW);
    localparam int NI   = row_nin(ROW);
    localparam int PW   = (ROW == 0) ? 0 : row_width(ROW-1);
    localparam int PB   = (ROW == 0) ? 0 : row_base(ROW-1);
    localparam int NS   = row_nskip(ROW);

    // slot 0 is a placeholder; each unit substitutes its own immediate
    logic [DW-1:0] cand [NCAND];

    always_comb begin
        for (int s = 0; s < NCAND; s++) cand[s] = '0;
        for (int j = 0; j < NI; j++) cand[1+j] = ext[row_in_idx(ROW, j)];
        for (int k = 0; k < PW; k++) cand[1+NI+k] = fu_res[PB+k];
        for (int k = 0; k < NS; k++) cand[1+NI+PW+k] = fu_res[skip_src(ROW, k)];
    end

    for (genvar j = 0; j < W; j++) begin : g_fu
        fu_cfg_t       uc;
        logic [DW-1:0] opa, opb;
        assign uc  = fcfg[BASE+j];
        assign opa = (uc.sel_a == '0) ? uc.imm : cand[uc.sel_a];
        assign opb = (uc.sel_b == '0) ? uc.imm : cand[uc.sel_b];
        afu_unit #(.CLS(unit_cls(j))) u_fu (
            .op (uc.op),
            .a  (opa),
            .b  (opb),
            .y  (row_y[j])
        );
    end

    logic unused_row;
    assign unused_row = ^{ext, fu_res, fcfg};
endmodule

// File: rtl/afu_outsel.sv
module afu_outsel
    import afu_pkg::*;
(
    input  osel_t [NOUT-1:0]          sel,
    input  logic  [NFU-1:0][DW-1:0]   fu_res,
    output logic  [NOUT-1:0][DW-1:0]  y,
    output logic  [NOUT-1:0]          en
);
    for (genvar k = 0; k < NOUT; k++) begin : g_lane
        assign en[k] = sel[k].en;
        assign y[k]  = sel[k].en ? fu_res[sel[k].src] : '0;
    end
endmodule

// File: rtl/afu_array.sv
module afu_array
    import afu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [NIN-1:0][DW-1:0]    opnd_i,
    input  logic [CFG_W-1:0]          cfg_i,
    output logic [NOUT-1:0][DW-1:0]   res_o,
    output logic [NOUT-1:0]           res_vld_o,
    output logic                      done_o
);
    logic [NIN-1:0][DW-1:0]  opnd_q;
    ci_cfg_t                 cfg_q;
    logic [1:0]              cnt_q;
    logic [NFU-1:0][DW-1:0]  fu_res;
    logic [NOUT-1:0][DW-1:0] out_y;
    logic [NOUT-1:0]         out_en;

    for (genvar r = 0; r < NROW; r++) begin : g_row
        localparam int RB = row_base(r);
        localparam int RW = row_width(r);
        logic [RW-1:0][DW-1:0] ry;
        afu_row #(.ROW(r)) u_row (
            .ext    (opnd_q),
            .fu_res (fu_res),
            .fcfg   (cfg_q.fu),
            .row_y  (ry)
        );
        assign fu_res[RB+RW-1:RB] = ry;
    end

    afu_outsel u_osel (
        .sel    (cfg_q.osel),
        .fu_res (fu_res),
        .y      (out_y),
        .en     (out_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            opnd_q    <= '0;
            cfg_q     <= '0;
            done_o    <= 1'b0;
            res_vld_o <= '0;
            res_o     <= '0;
        end else begin
            done_o    <= 1'b0;
            res_vld_o <= '0;
            if (cnt_q == 2'd0) begin
                if (start_i) begin
                    opnd_q <= opnd_i;
                    cfg_q  <= ci_cfg_t'(cfg_i);
                    cnt_q  <= lat_of(cfg_i[DEPW-1:0]);
                end
            end else begin
                cnt_q <= cnt_q - 2'd1;
                if (cnt_q == 2'd1) begin
                    done_o    <= 1'b1;
                    res_vld_o <= out_en;
                    res_o     <= out_y;
                end
            end
        end
    end

    logic unused_top;
    assign unused_top = ^cfg_q.depth;
endmodule

// File: rtl/afu_array_chk.sv
module afu_array_chk
    import afu_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input logic [DEPW-1:0]         depth_i,
    input logic                    done_o,
    input logic [NOUT-1:0]         res_vld_o,
    input logic [NOUT-1:0][DW-1:0] res_o
);
    logic [1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst)                    wcnt <= '0;
        else if (wcnt == 2'd0) begin
            if (start_i)            wcnt <= lat_of(depth_i);
        end else                    wcnt <= wcnt - 2'd1;
    end

    // R11
    wait_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wcnt == 2'd1) |=> done_o);

    // R11
    done_timing_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(wcnt) == 2'd1));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    vld_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|res_vld_o) |-> done_o);

    // R13
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(res_o));
endmodule

bind afu_array afu_array_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .depth_i   (cfg_i[afu_pkg::DEPW-1:0]),
    .done_o    (done_o),
    .res_vld_o (res_vld_o),
    .res_o     (res_o)
);

// File: tb/afu_array_tb.sv
`timescale 1ns/1ps
module afu_array_tb_top;
    import afu_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [NIN-1:0][DW-1:0]  opnd = '0;
    ci_cfg_t                 c = '0;
    logic [NOUT-1:0][DW-1:0] res;
    logic [NOUT-1:0]         vld;
    logic                    done;

    always #2.5 clk = ~clk;

    afu_array dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .opnd_i    (opnd),
        .cfg_i     (c),
        .res_o     (res),
        .res_vld_o (vld),
        .done_o    (done)
    );

    int    nchk = 0;
    int    nfail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference state
    int                      m_cnt = 0;
    ci_cfg_t                 m_cfg;
    logic [NIN-1:0][DW-1:0]  m_op;
    logic                    m_done = 0;
    logic [NOUT-1:0]         m_vld = '0;
    logic [NOUT-1:0][DW-1:0] m_res = '0;

    function automatic int ref_lat(int d);
        if (d <= 2) return 1;
        if (d <= 4) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] ref_op(int cls, int op, logic [31:0] a, logic [31:0] b);
        if (op == 0) return a;
        if (cls == 1) begin
            if (op == 1) return a ^ b;
            if (op == 2) return ~(a | b);
            if (op == 3) return a & b;
            if (op == 4) return a | b;
        end
        if (cls == 0) begin
            if (op == 5) return a + b;
            if (op == 6) return a - b;
            if (op == 7) return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        end
        if (cls == 2) begin
            if (op == 8) return a << b[4:0];
            if (op == 9) return a >> b[4:0];
        end
        return 32'd0;
    endfunction

    // source tags: value < 100 is an operand lane, 100+u is unit u
    function automatic void ref_eval(input ci_cfg_t cf, input logic [NIN-1:0][DW-1:0] x,
                                     output logic [NOUT-1:0][DW-1:0] y, output logic [NOUT-1:0] e);
        int wid[5];
        int bas[5];
        logic [31:0] u [16];
        int q[$];
        int g;
        wid = '{6, 4, 3, 2, 1};
        bas = '{0, 6, 10, 13, 15};
        g = 0;
        for (int r = 0; r < 5; r++) begin
            for (int p = 0; p < wid[r]; p++) begin
                logic [31:0] a, b;
                int sa, sb;
                q.delete();
                case (r)
                    0: for (int k = 0; k < 7; k++) q.push_back(k);
                    1: begin q.push_back(7); q.push_back(0); end
                    2: begin q.push_back(1); q.push_back(2); end
                    3: begin q.push_back(3); q.push_back(4); end
                    default: q.push_back(5);
                endcase
                if (r > 0) for (int k = 0; k < wid[r-1]; k++) q.push_back(100 + bas[r-1] + k);
                case (r)
                    2: q.push_back(105);
                    3: begin q.push_back(104); q.push_back(109); end
                    4: q.push_back(103);
                    default: ;
                endcase
                sa = int'(cf.fu[g].sel_a);
                sb = int'(cf.fu[g].sel_b);
                if (sa == 0) a = cf.fu[g].imm;
                else if (sa - 1 < q.size()) a = (q[sa-1] >= 100) ? u[q[sa-1]-100] : x[q[sa-1]];
                else a = '0;
                if (sb == 0) b = cf.fu[g].imm;
                else if (sb - 1 < q.size()) b = (q[sb-1] >= 100) ? u[q[sb-1]-100] : x[q[sb-1]];
                else b = '0;
                u[g] = ref_op(p % 3, int'(cf.fu[g].op), a, b);
                g++;
            end
        end
        for (int k = 0; k < NOUT; k++) begin
            e[k] = cf.osel[k].en;
            y[k] = cf.osel[k].en ? u[int'(cf.osel[k].src)] : 32'd0;
        end
    endfunction

    // advance the reference to the state after the coming rising edge
    task automatic model_edge();
        if (rst) begin
            m_cnt = 0; m_done = 0; m_vld = '0; m_res = '0;
        end else begin
            m_done = 0; m_vld = '0;
            if (m_cnt == 0) begin
                if (start) begin
                    m_cfg = c; m_op = opnd; m_cnt = ref_lat(int'(c.depth));
                end
            end else begin
                if (m_cnt == 1) begin
                    logic [NOUT-1:0][DW-1:0] ry;
                    logic [NOUT-1:0] re;
                    ref_eval(m_cfg, m_op, ry, re);
                    m_res = ry; m_vld = re; m_done = 1;
                end
                m_cnt--;
            end
        end
    endtask

    task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        string rq;
        check32(cur_req == "R1" ? "R1" : "R11", "done", {31'd0, done}, {31'd0, m_done});
        check32(cur_req == "R1" ? "R1" : "R10", "valid", {24'd0, vld}, {24'd0, m_vld});
        rq = (cur_req == "R1") ? "R1" : (m_done ? cur_req : "R13");
        for (int k = 0; k < NOUT; k++)
            check32(rq, $sformatf("lane %0d", k), res[k], m_res[k]);
    endtask

    task automatic cyc();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_fu(int g, int op, int sa, int sb, logic [31:0] imm);
        c.fu[g].op    = op_e'(op);
        c.fu[g].sel_a = SELW'(sa);
        c.fu[g].sel_b = SELW'(sb);
        c.fu[g].imm   = imm;
    endtask

    task automatic set_out(int k, int g);
        c.osel[k].en  = 1'b1;
        c.osel[k].src = UIDW'(g);
    endtask

    task automatic run_op(int d);
        c.depth = DEPW'(d);
        start = 1'b1;
        cyc();
        start = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R11 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc();
        rst = 1'b0;
        cyc();

        // R3 unit numbering: unit 0 adds, unit 15 forwards its immediate
        cur_req = "R3";
        c = '0;
        opnd[0] = 32'd5; opnd[1] = 32'd7;
        set_fu(0, 5, 1, 2, 0);
        set_fu(15, 0, 0, 0, 32'h0000ABCD);
        set_out(0, 0); set_out(1, 15);
        run_op(1);

        // R6 logical ops across rows 1..3
        cur_req = "R6";
        c = '0;
        opnd[0] = 32'hF0F0_1234; opnd[1] = 32'h0FF0_FFFF;
        opnd[2] = 32'h1111_0000; opnd[3] = 32'h0000_2222;
        set_fu(1, 1, 1, 2, 0);
        set_fu(4, 2, 3, 4, 0);
        set_fu(5, 0, 0, 0, 32'h8000_0001);
        set_fu(7, 3, 4, 0, 32'h0F0F_0F0F);
        set_fu(11, 4, 4, 7, 0);
        set_out(0, 1); set_out(1, 4); set_out(2, 7); set_out(3, 11);
        run_op(3);

        // R7 arithmetic: wrap, signed compare with mixed signs
        cur_req = "R7";
        c = '0;
        opnd[0] = 32'd3; opnd[1] = 32'hFFFF_FFFB; opnd[7] = 32'd1;
        set_fu(0, 6, 1, 2, 0);
        set_fu(3, 7, 2, 1, 0);
        set_fu(6, 5, 0, 1, 32'hFFFF_FFFF);
        set_fu(9, 7, 2, 1, 0);
        set_out(0, 0); set_out(1, 3); set_out(2, 6); set_out(3, 9);
        run_op(2);

        // R8 shifts use only the low five bits of the amount
        cur_req = "R8";
        c = '0;
        opnd[0] = 32'h0000_0003; opnd[1] = 32'd37;
        opnd[2] = 32'h8000_0000; opnd[3] = 32'd4; opnd[7] = 32'd31;
        set_fu(2, 8, 1, 2, 0);
        set_fu(5, 9, 3, 4, 0);
        set_fu(8, 8, 0, 1, 32'd1);
        set_out(0, 2); set_out(1, 5); set_out(2, 8);
        run_op(2);

        // R9 MOVE on a shift unit, wrong-class and undefined opcodes give 0
        cur_req = "R9";
        c = '0;
        opnd[0] = 32'h1234_5678; opnd[1] = 32'h0F0F_0F0F; opnd[4] = 32'hCAFE_0042;
        set_fu(2, 0, 5, 0, 0);
        set_fu(0, 1, 1, 2, 0);
        set_fu(1, 5, 1, 2, 0);
        set_fu(3, 12, 1, 2, 0);
        set_fu(5, 15, 1, 2, 0);
        set_out(0, 2); set_out(1, 0); set_out(2, 1); set_out(3, 3); set_out(4, 5);
        run_op(1);

        // R4 R5 lower-row inputs, skip links, out-of-range select
        cur_req = "R5";
        c = '0;
        for (int k = 0; k < NIN; k++) opnd[k] = 32'h100 * (k + 1) + 32'(k);
        set_fu(5, 0, 7, 0, 0);
        set_fu(12, 0, 7, 0, 0);
        set_fu(4, 0, 6, 0, 0);
        set_fu(9, 0, 1, 0, 0);
        set_fu(13, 5, 6, 7, 0);
        set_fu(3, 0, 4, 0, 0);
        set_fu(15, 5, 2, 4, 0);
        set_fu(14, 4, 9, 1, 0);
        set_fu(10, 5, 2, 1, 0);
        set_out(0, 12); set_out(1, 13); set_out(2, 15); set_out(3, 14);
        set_out(4, 9); set_out(5, 10);
        run_op(5);
        cur_req = "R4";
        c = '0;
        set_fu(6, 0, 2, 0, 0);
        set_fu(7, 0, 1, 0, 0);
        set_fu(15, 0, 1, 0, 0);
        set_fu(13, 0, 2, 0, 0);
        set_fu(0, 0, 15, 0, 0);
        set_out(0, 6); set_out(1, 7); set_out(2, 15); set_out(3, 13); set_out(4, 0);
        run_op(4);

        // R10 disabled lanes and two lanes on one unit
        cur_req = "R10";
        c = '0;
        opnd[0] = 32'hDEAD_BEEF;
        set_fu(0, 0, 1, 0, 0);
        set_out(2, 0); set_out(6, 0);
        c.osel[4].src = 4'd0;
        run_op(1);

        // R11 every depth code
        cur_req = "R11";
        for (int d = 0; d < 8; d++) begin
            c = '0;
            opnd[0] = 32'(d * 3); opnd[1] = 32'd100;
            set_fu(0, 5, 1, 2, 0);
            set_out(0, 0);
            run_op(d);
        end

        // R12 restarts mid-flight and at the result edge, inputs changed after accept
        cur_req = "R12";
        c = '0;
        opnd[0] = 32'd11; opnd[1] = 32'd22;
        set_fu(0, 5, 1, 2, 0);
        set_out(0, 0);
        c.depth = 3'd5;
        start = 1'b1;
        cyc();
        opnd[0] = 32'd1000; c.fu[0].op = OP_SUB;
        cyc();
        cyc();
        cyc();
        start = 1'b0;
        for (int i = 0; i < 6; i++) cyc();

        // R2 random configuration words
        cur_req = "R2";
        for (int n = 0; n < 300; n++) begin
            for (int g = 0; g < NFU; g++)
                set_fu(g, $urandom_range(0, 11), $urandom_range(0, 15),
                       $urandom_range(0, 15), $urandom);
            for (int k = 0; k < NOUT; k++) begin
                c.osel[k].en  = 1'($urandom_range(0, 3) != 0);
                c.osel[k].src = UIDW'($urandom_range(0, 15));
            end
            for (int k = 0; k < NIN; k++) opnd[k] = $urandom;
            c.depth = DEPW'($urandom_range(0, 7));
            start = 1'b1;
            cyc();
            start = 1'($urandom_range(0, 1));
            for (int i = 0; i < $urandom_range(2, 4); i++) begin
                cyc();
                start = 1'($urandom_range(0, 1));
            end
            start = 1'b0;
            for (int i = 0; i < 3; i++) cyc();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule